// File: doc/BRIEF.md
# CAN Interframe Space and Overload Controller

This block follows the bus from the end of any frame until the next data or remote frame begins. It counts the recessive intermission bits and decides what a dominant bit seen there means: an illegal condition that calls for an overload frame, or the start of the next frame. It also raises an overload frame when the local receiver reports that it cannot yet accept another message. Every decision is made at bit-time granularity. A decision is taken only on a cycle where the bit strobe is high, and its result appears on the registered outputs one clock later.

While an overload frame is active, the block drives six dominant flag bits on its transmit output. It then listens while other nodes echo the flag and counts the eight recessive delimiter bits. After the delimiter the intermission count restarts from zero. The block has no data stream and so no valid/ready handshake. It takes one bus bit per strobe and cannot apply back-pressure. The caller must present a new sampled bit on each strobe. Bit timing, frame reception and error counting sit outside the block and drive its inputs.

Top module: `can_ifs_ovl_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the outputs read tx_bit=1, bus_idle=1, ovl_active=0 and sof_pulse=0.
- R2: An end-of-frame pulse during a frame starts an intermission at slot 0, and bus_idle stays 0 in that time. After three strobes with a recessive bit (rx_bit=1), bus_idle reads 1 from the clock that follows the third strobe.
- R3: A dominant bit (rx_bit=0) sampled in intermission slot 0 or 1 starts an overload frame: ovl_active=1 and tx_bit=0 from the next clock. tx_bit stays 0 for exactly six bit strobes.
- R4: A dominant bit sampled in intermission slot 2 gives a one-clock sof_pulse and starts no overload frame.
- R5: A dominant bit sampled while the bus is idle gives a one-clock sof_pulse, and bus_idle falls in the same clock.
- R6: After the flag, tx_bit is recessive. The delimiter lasts eight recessive bit times, and the first recessive bit after the flag counts as its first bit. When the delimiter ends, ovl_active falls and the intermission restarts from slot 0, so a dominant bit on the third bit after the delimiter is a start of frame.
- R7: Dominant bits that other nodes echo after the flag extend the overload frame. After six echo bits, which makes twelve dominant bits in all, the delimiter count starts whatever the bus level is.
- R8: rcv_not_ready=1 sampled with a recessive bit in intermission slot 0 or 1 starts an overload frame. At most two such frames occur between two frame starts, and a request after the second is ignored.
- R9: The count of not-ready overload frames clears when a frame starts, so a later request is honoured again.
- R10: An end-of-frame pulse while the bus is idle is ignored, and bus_idle stays 1.
- R11: Bus bits and requests on cycles without a bit strobe have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-clock strobe at each bus sample point |
| rx_bit | input | 1 | Sampled bus level, 1 recessive, 0 dominant |
| eof_pulse | input | 1 | End of the current frame, from the frame logic |
| rcv_not_ready | input | 1 | Receiver asks for a delay of the next message |
| tx_bit | output | 1 | Bit level to transmit, 0 during the overload flag |
| sof_pulse | output | 1 | One-clock pulse when a frame start is recognised |
| bus_idle | output | 1 | Intermission complete and bus recessive |
| ovl_active | output | 1 | Overload flag, echo or delimiter in progress |

## Verification
The bench puts a dominant bit on each intermission slot in turn. A design that treats the third slot like the first two would emit an overload flag where a frame start is due. A design that does the reverse would let an illegal dominant bit pass as a frame start. The bench measures the flag length and the delimiter length both with and without echo bits. An off-by-one counter would stretch or shorten the frame by a bit, and a missing twelve-bit cap would leave the block waiting on a stuck dominant bus. It also sends three not-ready requests in a row and then one after a frame start. A missing limit would issue a third overload frame, and a counter that is never cleared would refuse the later request.

// File: rtl/can_ifs_pkg.sv
package can_ifs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_INTER,
    ST_FLAG,
    ST_ECHO,
    ST_DELIM
  } ifs_state_e;

  typedef enum logic [1:0] {
    CNT_HOLD,
    CNT_CLR,
    CNT_INC,
    CNT_ONE
  } cnt_op_e;

endpackage

// File: rtl/can_ifs_bitcnt.sv
module can_ifs_bitcnt
  import can_ifs_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  cnt_op_e      op,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else begin
      unique case (op)
        CNT_CLR:  cnt <= '0;
        CNT_INC:  cnt <= cnt + W'(1);
        CNT_ONE:  cnt <= W'(1);
        default:  cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/can_ifs_classify.sv
module can_ifs_classify #(
  parameter int SW       = 4,
  parameter int SOF_SLOT = 2
) (
  input  logic          bit_stb,
  input  logic          rx_bit,
  input  logic          in_idle,
  input  logic          in_inter,
  input  logic [SW-1:0] slot,
  input  logic          nr_req,
  input  logic          nr_allow,
  output logic          hit_sof,
  output logic          hit_ovl,
  output logic          hit_nr
);

  logic early_slot;
  logic last_slot;
  logic dominant;

  always_comb begin
    dominant   = !rx_bit;
    early_slot = in_inter && (slot < SW'(SOF_SLOT));
    last_slot  = in_inter && (slot == SW'(SOF_SLOT));
    hit_sof    = bit_stb && dominant && (in_idle || last_slot);
    hit_ovl    = bit_stb && early_slot && (dominant || (nr_req && nr_allow));
    hit_nr     = hit_ovl && !dominant;
  end

endmodule

// File: rtl/can_ifs_nr_limit.sv
module can_ifs_nr_limit #(
  parameter int MAX_OVL = 2,
  parameter int W       = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic         allow,
  output logic [W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc && allow) begin
      cnt <= cnt + W'(1);
    end
  end

  assign allow = (cnt < W'(MAX_OVL));

endmodule

// File: rtl/can_ifs_ovl_ctrl.sv
module can_ifs_ovl_ctrl
  import can_ifs_pkg::*;
#(
  parameter int INTER_BITS   = 3,
  parameter int FLAG_BITS    = 6,
  parameter int MAX_DOM_BITS = 12,
  parameter int DELIM_BITS   = 8,
  parameter int MAX_NR_OVL   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_stb,
  input  logic rx_bit,
  input  logic eof_pulse,
  input  logic rcv_not_ready,
  output logic tx_bit,
  output logic sof_pulse,
  output logic bus_idle,
  output logic ovl_active
);

  localparam int ECHO_MAX = MAX_DOM_BITS - FLAG_BITS;
  localparam int M_A      = (DELIM_BITS > FLAG_BITS) ? DELIM_BITS : FLAG_BITS;
  localparam int M_B      = (ECHO_MAX > INTER_BITS) ? ECHO_MAX : INTER_BITS;
  localparam int CNT_MAX  = (M_A > M_B) ? M_A : M_B;
  localparam int CW       = $clog2(CNT_MAX + 1);
  localparam int SOF_SLOT = INTER_BITS - 1;
  localparam int NRW      = $clog2(MAX_NR_OVL + 1);

  ifs_state_e      state, state_d;
  cnt_op_e         cnt_op;
  logic [CW-1:0]   cnt;
  logic [NRW-1:0]  nr_cnt;
  logic            nr_allow, nr_inc, nr_clr;
  logic            hit_sof, hit_ovl, hit_nr;
  logic            sof_d;

  can_ifs_bitcnt #(.W(CW)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (cnt_op),
    .cnt   (cnt)
  );

  can_ifs_classify #(.SW(CW), .SOF_SLOT(SOF_SLOT)) u_cls (
    .bit_stb  (bit_stb),
    .rx_bit   (rx_bit),
    .in_idle  (state == ST_IDLE),
    .in_inter (state == ST_INTER),
    .slot     (cnt),
    .nr_req   (rcv_not_ready),
    .nr_allow (nr_allow),
    .hit_sof  (hit_sof),
    .hit_ovl  (hit_ovl),
    .hit_nr   (hit_nr)
  );

  can_ifs_nr_limit #(.MAX_OVL(MAX_NR_OVL), .W(NRW)) u_nr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (nr_clr),
    .inc   (nr_inc),
    .allow (nr_allow),
    .cnt   (nr_cnt)
  );

  always_comb begin
    state_d = state;
    cnt_op  = CNT_HOLD;
    sof_d   = 1'b0;
    nr_inc  = 1'b0;
    nr_clr  = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (hit_sof) begin
          state_d = ST_FRAME;
          sof_d   = 1'b1;
          nr_clr  = 1'b1;
        end
      end
      ST_FRAME: begin
        if (eof_pulse) begin
          state_d = ST_INTER;
          cnt_op  = CNT_CLR;
        end
      end
      ST_INTER: begin
        if (hit_sof) begin
          state_d = ST_FRAME;
          sof_d   = 1'b1;
          nr_clr  = 1'b1;
          cnt_op  = CNT_CLR;
        end else if (hit_ovl) begin
          state_d = ST_FLAG;
          cnt_op  = CNT_CLR;
          nr_inc  = hit_nr;
        end else if (bit_stb) begin
          if (cnt == CW'(SOF_SLOT)) begin
            state_d = ST_IDLE;
            cnt_op  = CNT_CLR;
          end else begin
            cnt_op = CNT_INC;
          end
        end
      end
      ST_FLAG: begin
        if (bit_stb) begin
          if (cnt == CW'(FLAG_BITS - 1)) begin
            state_d = ST_ECHO;
            cnt_op  = CNT_CLR;
          end else begin
            cnt_op = CNT_INC;
          end
        end
      end
      ST_ECHO: begin
        if (bit_stb) begin
          if (rx_bit) begin
            state_d = ST_DELIM;
            cnt_op  = CNT_ONE;
          end else if (cnt == CW'(ECHO_MAX - 1)) begin
            state_d = ST_DELIM;
            cnt_op  = CNT_CLR;
          end else begin
            cnt_op = CNT_INC;
          end
        end
      end
      ST_DELIM: begin
        if (bit_stb) begin
          if (cnt == CW'(DELIM_BITS - 1)) begin
            state_d = ST_INTER;
            cnt_op  = CNT_CLR;
          end else begin
            cnt_op = CNT_INC;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      tx_bit     <= 1'b1;
      sof_pulse  <= 1'b0;
      bus_idle   <= 1'b1;
      ovl_active <= 1'b0;
    end else begin
      state      <= state_d;
      tx_bit     <= (state_d != ST_FLAG);
      sof_pulse  <= sof_d;
      bus_idle   <= (state_d == ST_IDLE);
      ovl_active <= (state_d == ST_FLAG) || (state_d == ST_ECHO) ||
                    (state_d == ST_DELIM);
    end
  end

endmodule

// File: rtl/can_ifs_ovl_ctrl_chk.sv
module can_ifs_ovl_ctrl_chk #(
  parameter int FLAG_BITS  = 6,
  parameter int MAX_NR_OVL = 2,
  parameter int NRW        = $clog2(MAX_NR_OVL + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bit_stb,
  input logic           tx_bit,
  input logic           sof_pulse,
  input logic           bus_idle,
  input logic           ovl_active,
  input logic [NRW-1:0] nr_cnt
);

  localparam int LW = $clog2(FLAG_BITS + 2) + 1;

  logic [LW-1:0] low_run;

  always_ff @(posedge clk) begin
    if (!rst_n)      low_run <= '0;
    else if (tx_bit) low_run <= '0;
    else if (bit_stb) low_run <= low_run + LW'(1);
  end

  p_flag_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= LW'(FLAG_BITS));

  p_tx_in_ovl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_bit |-> ovl_active);

  p_sof_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |=> !sof_pulse);

  p_sof_no_ovl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> (!bus_idle && !ovl_active));

  p_idle_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_idle && ovl_active));

  p_ovl_on_stb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl_active) |-> $past(bit_stb));

  p_sof_on_stb_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> $past(bit_stb));

  p_nr_limit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nr_cnt <= NRW'(MAX_NR_OVL));

endmodule

bind can_ifs_ovl_ctrl can_ifs_ovl_ctrl_chk #(
  .FLAG_BITS  (FLAG_BITS),
  .MAX_NR_OVL (MAX_NR_OVL)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bit_stb    (bit_stb),
  .tx_bit     (tx_bit),
  .sof_pulse  (sof_pulse),
  .bus_idle   (bus_idle),
  .ovl_active (ovl_active),
  .nr_cnt     (nr_cnt)
);

// File: tb/can_ifs_ovl_ctrl_tb.sv
module can_ifs_ovl_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_stb = 1'b0;
  logic rx_bit = 1'b1;
  logic eof_pulse = 1'b0;
  logic rcv_not_ready = 1'b0;
  logic tx_bit, sof_pulse, bus_idle, ovl_active;

  int n_chk = 0;
  int n_err = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  can_ifs_ovl_ctrl u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_stb       (bit_stb),
    .rx_bit        (rx_bit),
    .eof_pulse     (eof_pulse),
    .rcv_not_ready (rcv_not_ready),
    .tx_bit        (tx_bit),
    .sof_pulse     (sof_pulse),
    .bus_idle      (bus_idle),
    .ovl_active    (ovl_active)
  );

  // Row: [10] eof pulse instead of strobe, [9] rx, [8] not-ready,
  //      [7:4] expected {tx, idle, ovl, sof}, [3:0] requirement number
  localparam int NROW = 27;
  localparam logic [10:0] TAB [NROW] = '{
    11'b1_1_0_1100_1010,  // R10 eof while idle ignored
    11'b0_0_0_1001_0101,  // R5 dominant in idle
    11'b1_1_0_1000_0010,  // R2 eof opens intermission
    11'b0_1_0_1000_0010,  // R2 slot 0
    11'b0_1_0_1000_0010,  // R2 slot 1
    11'b0_1_0_1100_0010,  // R2 slot 2 -> idle
    11'b0_0_0_1001_0101,  // R5 frame start
    11'b1_1_0_1000_0010,  // R2
    11'b0_1_0_1000_0010,  // R2 slot 0
    11'b0_0_0_0010_0011,  // R3 dominant in slot 1
    11'b0_0_0_0010_0011,  // R3 flag bit 1
    11'b0_0_0_0010_0011,  // R3 flag bit 2
    11'b0_0_0_0010_0011,  // R3 flag bit 3
    11'b0_0_0_0010_0011,  // R3 flag bit 4
    11'b0_0_0_0010_0011,  // R3 flag bit 5
    11'b0_0_0_1010_0011,  // R3 flag bit 6 -> recessive
    11'b0_1_0_1010_0110,  // R6 delimiter bit 1
    11'b0_1_0_1010_0110,  // R6
    11'b0_1_0_1010_0110,  // R6
    11'b0_1_0_1010_0110,  // R6
    11'b0_1_0_1010_0110,  // R6
    11'b0_1_0_1010_0110,  // R6
    11'b0_1_0_1010_0110,  // R6 delimiter bit 7
    11'b0_1_0_1000_0110,  // R6 delimiter bit 8 -> intermission
    11'b0_1_0_1000_0110,  // R6 slot 0
    11'b0_1_0_1000_0110,  // R6 slot 1
    11'b0_0_0_1001_0100   // R4 dominant in slot 2 is a frame start
  };

  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {tx_bit, bus_idle, ovl_active, sof_pulse};
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s {tx,idle,ovl,sof} got %b exp %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic rx, input logic nr);
    @(negedge clk);
    rx_bit = rx;
    rcv_not_ready = nr;
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
    rcv_not_ready = 1'b0;
  endtask

  task automatic eof();
    @(negedge clk);
    eof_pulse = 1'b1;
    @(negedge clk);
    eof_pulse = 1'b0;
  endtask

  task automatic ovl_tail();
    repeat (6) step(1'b0, 1'b0);
    repeat (8) step(1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 in reset", 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", 4'b1100);

    for (int i = 0; i < NROW; i++) begin
      if (TAB[i][10]) eof();
      else step(TAB[i][9], TAB[i][8]);
      chk($sformatf("R%0d row %0d", TAB[i][3:0], i), TAB[i][7:4]);
    end

    // R11: no strobe, no effect
    eof();
    rx_bit = 1'b0;
    repeat (4) @(negedge clk);
    chk("R11 intermission holds without strobe", 4'b1000);
    repeat (3) step(1'b1, 1'b0);
    chk("R2 idle after three recessive", 4'b1100);
    rx_bit = 1'b0;
    rcv_not_ready = 1'b1;
    repeat (4) @(negedge clk);
    chk("R11 idle holds without strobe", 4'b1100);
    rcv_not_ready = 1'b0;

    // R7: echo bits extend the frame
    step(1'b0, 1'b0);
    eof();
    step(1'b0, 1'b0);
    repeat (6) step(1'b0, 1'b0);
    repeat (2) step(1'b0, 1'b0);
    chk("R7 echo keeps frame", 4'b1010);
    step(1'b1, 1'b0);
    repeat (6) step(1'b1, 1'b0);
    chk("R7 delimiter after echo", 4'b1010);
    step(1'b1, 1'b0);
    chk("R7 frame ends after 8 recessive", 4'b1000);

    // R7: twelve-bit cap
    step(1'b0, 1'b0);
    repeat (6) step(1'b0, 1'b0);
    repeat (6) step(1'b0, 1'b0);
    chk("R7 six echo bits", 4'b1010);
    repeat (7) step(1'b0, 1'b0);
    chk("R7 capped delimiter bit 7", 4'b1010);
    step(1'b0, 1'b0);
    chk("R7 capped delimiter done", 4'b1000);

    // R8: not-ready limit
    repeat (3) step(1'b1, 1'b0);
    chk("R2 idle again", 4'b1100);
    step(1'b0, 1'b0);
    eof();
    step(1'b1, 1'b1);
    chk("R8 first not-ready overload", 4'b0010);
    ovl_tail();
    chk("R8 back in intermission", 4'b1000);
    step(1'b1, 1'b1);
    chk("R8 second not-ready overload", 4'b0010);
    ovl_tail();
    step(1'b1, 1'b1);
    chk("R8 third request slot 0 ignored", 4'b1000);
    step(1'b1, 1'b1);
    chk("R8 third request slot 1 ignored", 4'b1000);
    step(1'b1, 1'b0);
    chk("R8 idle reached", 4'b1100);

    // R9: counter clears on frame start
    step(1'b0, 1'b0);
    chk("R9 frame start", 4'b1001);
    eof();
    step(1'b1, 1'b1);
    chk("R9 request honoured again", 4'b0010);
    ovl_tail();

    // R1: reset in the middle of an overload frame
    step(1'b0, 1'b0);
    chk("R3 overload before reset", 4'b0010);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset mid overload", 4'b1100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after second reset", 4'b1100);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired got running exp done");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule